// File: doc/BRIEF.md
# Two-Way Masked Semaphore Interrupt Channel

This block connects a host processor and a DSP with two 16-bit semaphore registers, one for each direction. The sending side of a direction raises bits through its set port. The receiving side clears bits through its acknowledge port, reads the current value and holds a 16-bit mask. Each receiver has a summary flag that is high while any unmasked semaphore bit is pending. The receiver gets a one-cycle interrupt pulse each time that flag goes from low to high.

Because the interrupt follows the edge of a masked OR, a mask write on its own can raise an interrupt: unmasking a bit that is already pending is enough. Both sides share one clock. The register ports are plain write strobes with data, so the bus decoder that drives them sits outside this block.

Top module: `sema_pair`

## Requirements
- R1: While `rst_n` is low and in the cycle after it is released, every get value, every mask, both summary flags and both interrupts are zero.
- R2: A set write (`*_set_we` high at a clock edge) ORs `*_set_bits` into the semaphore travelling from that side to the other side. The result shows on the other side's `*_get` from the next cycle on.
- R3: An acknowledge write clears, in the semaphore the acknowledging side receives, every bit written as 1. Bits written as 0 keep their value.
- R4: If a set and an acknowledge hit the same bit at the same edge, the bit ends up 1.
- R5: A semaphore value changes only through a set write from its sender or an acknowledge write from its receiver. Writes aimed at the other direction, and mask writes, leave it unchanged.
- R6: Each receiver's `*_summary` equals the OR of (its get value AND NOT its mask). It follows a mask write in the cycle after the write edge, with no other event.
- R7: `*_irq` is high for exactly the first cycle in which the matching summary is 1 after being 0. It stays low while the summary remains 1.
- R8: A mask write that unmasks an already pending bit raises the interrupt, with no semaphore write.
- R9: `*_mask` reads back the value of the last mask write made by that side.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock shared by both sides |
| rst_n | input | 1 | Synchronous active-low reset |
| host_set_we | input | 1 | Host sets bits in the host-to-DSP semaphore |
| host_set_bits | input | 16 | Bits to set |
| host_ack_we | input | 1 | Host clears bits in the DSP-to-host semaphore |
| host_ack_bits | input | 16 | Bits to clear |
| host_mask_we | input | 1 | Host loads its mask |
| host_mask_bits | input | 16 | New host mask (1 = masked) |
| host_get | output | 16 | DSP-to-host semaphore value |
| host_mask | output | 16 | Current host mask |
| host_summary | output | 1 | Any unmasked DSP-to-host bit pending |
| host_irq | output | 1 | One-cycle pulse on rise of host_summary |
| dsp_set_we | input | 1 | DSP sets bits in the DSP-to-host semaphore |
| dsp_set_bits | input | 16 | Bits to set |
| dsp_ack_we | input | 1 | DSP clears bits in the host-to-DSP semaphore |
| dsp_ack_bits | input | 16 | Bits to clear |
| dsp_mask_we | input | 1 | DSP loads its mask |
| dsp_mask_bits | input | 16 | New DSP mask (1 = masked) |
| dsp_get | output | 16 | Host-to-DSP semaphore value |
| dsp_mask | output | 16 | Current DSP mask |
| dsp_summary | output | 1 | Any unmasked host-to-DSP bit pending |
| dsp_irq | output | 1 | One-cycle pulse on rise of dsp_summary |

## Verification
On every cycle and for each direction, the assertions check four things. Set bits arrive, acknowledged bits leave unless a set covers them, the value holds when nothing writes it, and the summary matches the masked value. They also tie every interrupt pulse to a summary rising edge and check that each rising edge gives a pulse. Only the bench scenarios show the rest: the exact values after reset, set winning over acknowledge on one bit, one direction staying untouched by the other direction's traffic, and an interrupt raised by a mask write alone.

// File: rtl/sema_pkg.sv
// Package: shared constants for the semaphore channel pair.
// Assumes both directions use the same semaphore width.
package sema_pkg;
    localparam int SEM_W   = 16;
    localparam int NUM_DIR = 2;
    // Lane index: host-to-DSP is lane 0, DSP-to-host is lane 1.
    localparam int LANE_H2D = 0;
    localparam int LANE_D2H = 1;
endpackage

// File: rtl/sema_store.sv
// sema_store: holds one direction's semaphore value.
// The sender ORs bits in and the receiver clears bits. Where both touch a
// bit at one edge, the set wins. Assumes one clock and synchronous active-low reset.
module sema_store #(
    parameter int WIDTH = sema_pkg::SEM_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             set_we,
    input  logic [WIDTH-1:0] set_bits,
    input  logic             ack_we,
    input  logic [WIDTH-1:0] ack_bits,
    output logic [WIDTH-1:0] value
);
    logic [WIDTH-1:0] set_eff;
    logic [WIDTH-1:0] clr_eff;
    logic [WIDTH-1:0] value_q;

    // Gate the write data with the strobes.
    always_comb begin
        set_eff = set_we ? set_bits : '0;
        clr_eff = ack_we ? ack_bits : '0;
    end

    // Update the value: clear first, then OR in the set bits.
    always_ff @(posedge clk) begin
        if (!rst_n) value_q <= '0;
        else        value_q <= (value_q & ~clr_eff) | set_eff;
    end

    assign value = value_q;
endmodule

// File: rtl/sema_notify.sv
// sema_notify: receiver-side mask, summary flag and rising-edge interrupt.
// The summary is combinational from the stored value and mask, so a mask
// change shows up as soon as the mask register updates. The interrupt is
// high in the first cycle the summary is 1 after being 0.
module sema_notify #(
    parameter int WIDTH = sema_pkg::SEM_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             mask_we,
    input  logic [WIDTH-1:0] mask_bits,
    input  logic [WIDTH-1:0] value,
    output logic [WIDTH-1:0] mask,
    output logic             summary,
    output logic             irq
);
    logic [WIDTH-1:0] mask_q;
    logic             summary_d;
    logic             summary_q;

    // Load the mask on a mask write.
    always_ff @(posedge clk) begin
        if (!rst_n)       mask_q <= '0;
        else if (mask_we) mask_q <= mask_bits;
    end

    // Reduce the unmasked pending bits to one flag.
    always_comb begin
        summary_d = |(value & ~mask_q);
    end

    // Remember the flag from the previous cycle for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) summary_q <= 1'b0;
        else        summary_q <= summary_d;
    end

    assign mask    = mask_q;
    assign summary = summary_d;
    assign irq     = summary_d & ~summary_q;
endmodule

// File: rtl/sema_lane.sv
// sema_lane: one complete direction, with the value store and the receiver
// notify logic. Assumes the sender and receiver ports are already split.
module sema_lane #(
    parameter int WIDTH = sema_pkg::SEM_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             set_we,
    input  logic [WIDTH-1:0] set_bits,
    input  logic             ack_we,
    input  logic [WIDTH-1:0] ack_bits,
    input  logic             mask_we,
    input  logic [WIDTH-1:0] mask_bits,
    output logic [WIDTH-1:0] value,
    output logic [WIDTH-1:0] mask,
    output logic             summary,
    output logic             irq
);
    logic [WIDTH-1:0] value_w;

    sema_store #(.WIDTH(WIDTH)) u_store (
        .clk      (clk),
        .rst_n    (rst_n),
        .set_we   (set_we),
        .set_bits (set_bits),
        .ack_we   (ack_we),
        .ack_bits (ack_bits),
        .value    (value_w)
    );

    sema_notify #(.WIDTH(WIDTH)) u_notify (
        .clk       (clk),
        .rst_n     (rst_n),
        .mask_we   (mask_we),
        .mask_bits (mask_bits),
        .value     (value_w),
        .mask      (mask),
        .summary   (summary),
        .irq       (irq)
    );

    assign value = value_w;
endmodule

// File: rtl/sema_pair.sv
// sema_pair: two semaphore lanes between a host and a DSP.
// Lane 0 carries host-to-DSP: the host sets, the DSP acknowledges and masks.
// Lane 1 carries DSP-to-host: the DSP sets, the host acknowledges and masks.
// Assumes both sides run on one clock; bus decoding is done outside.
module sema_pair #(
    parameter int WIDTH = sema_pkg::SEM_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             host_set_we,
    input  logic [WIDTH-1:0] host_set_bits,
    input  logic             host_ack_we,
    input  logic [WIDTH-1:0] host_ack_bits,
    input  logic             host_mask_we,
    input  logic [WIDTH-1:0] host_mask_bits,
    output logic [WIDTH-1:0] host_get,
    output logic [WIDTH-1:0] host_mask,
    output logic             host_summary,
    output logic             host_irq,
    input  logic             dsp_set_we,
    input  logic [WIDTH-1:0] dsp_set_bits,
    input  logic             dsp_ack_we,
    input  logic [WIDTH-1:0] dsp_ack_bits,
    input  logic             dsp_mask_we,
    input  logic [WIDTH-1:0] dsp_mask_bits,
    output logic [WIDTH-1:0] dsp_get,
    output logic [WIDTH-1:0] dsp_mask,
    output logic             dsp_summary,
    output logic             dsp_irq
);
    import sema_pkg::*;

    logic             snd_we   [NUM_DIR];
    logic [WIDTH-1:0] snd_bits [NUM_DIR];
    logic             rcv_ack  [NUM_DIR];
    logic [WIDTH-1:0] rcv_ackb [NUM_DIR];
    logic             rcv_mwe  [NUM_DIR];
    logic [WIDTH-1:0] rcv_mb   [NUM_DIR];
    logic [WIDTH-1:0] ln_value [NUM_DIR];
    logic [WIDTH-1:0] ln_mask  [NUM_DIR];
    logic             ln_sum   [NUM_DIR];
    logic             ln_irq   [NUM_DIR];

    // Route each side's write ports onto the lane it drives.
    always_comb begin
        snd_we[LANE_H2D]   = host_set_we;
        snd_bits[LANE_H2D] = host_set_bits;
        rcv_ack[LANE_H2D]  = dsp_ack_we;
        rcv_ackb[LANE_H2D] = dsp_ack_bits;
        rcv_mwe[LANE_H2D]  = dsp_mask_we;
        rcv_mb[LANE_H2D]   = dsp_mask_bits;
        snd_we[LANE_D2H]   = dsp_set_we;
        snd_bits[LANE_D2H] = dsp_set_bits;
        rcv_ack[LANE_D2H]  = host_ack_we;
        rcv_ackb[LANE_D2H] = host_ack_bits;
        rcv_mwe[LANE_D2H]  = host_mask_we;
        rcv_mb[LANE_D2H]   = host_mask_bits;
    end

    for (genvar d = 0; d < NUM_DIR; d++) begin : g_lane
        sema_lane #(.WIDTH(WIDTH)) u_lane (
            .clk       (clk),
            .rst_n     (rst_n),
            .set_we    (snd_we[d]),
            .set_bits  (snd_bits[d]),
            .ack_we    (rcv_ack[d]),
            .ack_bits  (rcv_ackb[d]),
            .mask_we   (rcv_mwe[d]),
            .mask_bits (rcv_mb[d]),
            .value     (ln_value[d]),
            .mask      (ln_mask[d]),
            .summary   (ln_sum[d]),
            .irq       (ln_irq[d])
        );
    end

    // Present each lane's receiver outputs on the receiving side's ports.
    assign dsp_get      = ln_value[LANE_H2D];
    assign dsp_mask     = ln_mask[LANE_H2D];
    assign dsp_summary  = ln_sum[LANE_H2D];
    assign dsp_irq      = ln_irq[LANE_H2D];
    assign host_get     = ln_value[LANE_D2H];
    assign host_mask    = ln_mask[LANE_D2H];
    assign host_summary = ln_sum[LANE_D2H];
    assign host_irq     = ln_irq[LANE_D2H];
endmodule

// File: rtl/sema_chk.sv
// sema_chk: per-direction protocol checker, bound twice to sema_pair.
// It sees the sender's set port and the receiver's acknowledge, mask and
// output ports of one direction.
module sema_chk #(
    parameter int WIDTH = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             set_we,
    input logic [WIDTH-1:0] set_bits,
    input logic             ack_we,
    input logic [WIDTH-1:0] ack_bits,
    input logic             mask_we,
    input logic [WIDTH-1:0] mask_bits,
    input logic [WIDTH-1:0] get,
    input logic [WIDTH-1:0] mask,
    input logic             summary,
    input logic             irq
);
    p_set_sticks_r2: assert property (@(posedge clk) disable iff (!rst_n)
        set_we |=> ((get & $past(set_bits)) == $past(set_bits)));

    p_ack_clears_r3: assert property (@(posedge clk) disable iff (!rst_n)
        ack_we |=> ((get & $past(ack_bits) & ~$past(set_we ? set_bits : '0)) == '0));

    p_quiet_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!set_we && !ack_we) |=> $stable(get));

    p_summary_r6: assert property (@(posedge clk) disable iff (!rst_n)
        summary == |(get & ~mask));

    p_mask_load_r9: assert property (@(posedge clk) disable iff (!rst_n)
        mask_we |=> (mask == $past(mask_bits)));

    p_irq_on_edge_r7: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (summary && !$past(summary)));

    p_edge_gives_irq_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (summary && !$past(summary)) |-> irq);
endmodule

bind sema_pair sema_chk #(.WIDTH(WIDTH)) u_chk_h2d (
    .clk(clk), .rst_n(rst_n),
    .set_we(host_set_we), .set_bits(host_set_bits),
    .ack_we(dsp_ack_we), .ack_bits(dsp_ack_bits),
    .mask_we(dsp_mask_we), .mask_bits(dsp_mask_bits),
    .get(dsp_get), .mask(dsp_mask), .summary(dsp_summary), .irq(dsp_irq)
);

bind sema_pair sema_chk #(.WIDTH(WIDTH)) u_chk_d2h (
    .clk(clk), .rst_n(rst_n),
    .set_we(dsp_set_we), .set_bits(dsp_set_bits),
    .ack_we(host_ack_we), .ack_bits(host_ack_bits),
    .mask_we(host_mask_we), .mask_bits(host_mask_bits),
    .get(host_get), .mask(host_mask), .summary(host_summary), .irq(host_irq)
);

// File: tb/sema_pair_test.sv
`timescale 1ns/100ps
// Bench: behavioural per-cycle model of both lanes, compared at every negedge.
module sema_pair_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        h_swe = 0, h_awe = 0, h_mwe = 0;
    logic [15:0] h_sb = 0, h_ab = 0, h_mb = 0;
    logic        d_swe = 0, d_awe = 0, d_mwe = 0;
    logic [15:0] d_sb = 0, d_ab = 0, d_mb = 0;
    logic [15:0] host_get, host_mask, dsp_get, dsp_mask;
    logic        host_summary, host_irq, dsp_summary, dsp_irq;

    int checks = 0;
    int errors = 0;
    string phase = "R1";
    bit done = 0;

    // Model state: index 0 host-to-DSP, 1 DSP-to-host.
    logic [15:0] m_sem [2];
    logic [15:0] m_msk [2];
    logic        m_prev [2];

    always #2.5 clk = ~clk;

    sema_pair uut (
        .clk(clk), .rst_n(rst_n),
        .host_set_we(h_swe), .host_set_bits(h_sb),
        .host_ack_we(h_awe), .host_ack_bits(h_ab),
        .host_mask_we(h_mwe), .host_mask_bits(h_mb),
        .host_get(host_get), .host_mask(host_mask),
        .host_summary(host_summary), .host_irq(host_irq),
        .dsp_set_we(d_swe), .dsp_set_bits(d_sb),
        .dsp_ack_we(d_awe), .dsp_ack_bits(d_ab),
        .dsp_mask_we(d_mwe), .dsp_mask_bits(d_mb),
        .dsp_get(dsp_get), .dsp_mask(dsp_mask),
        .dsp_summary(dsp_summary), .dsp_irq(dsp_irq)
    );

    function automatic logic sum_of(int d);
        return (m_sem[d] & ~m_msk[d]) != 16'h0;
    endfunction

    // Model update at each clock edge from the inputs driven after the last edge.
    always @(posedge clk) begin
        if (!rst_n) begin
            for (int d = 0; d < 2; d++) begin
                m_sem[d] = 0; m_msk[d] = 0; m_prev[d] = 0;
            end
        end else begin
            for (int d = 0; d < 2; d++) m_prev[d] = sum_of(d);
            m_sem[0] = (m_sem[0] & ~(d_awe ? d_ab : 16'h0)) | (h_swe ? h_sb : 16'h0);
            m_sem[1] = (m_sem[1] & ~(h_awe ? h_ab : 16'h0)) | (d_swe ? d_sb : 16'h0);
            if (d_mwe) m_msk[0] = d_mb;
            if (h_mwe) m_msk[1] = h_mb;
        end
    end

    task automatic cmp(string what, int lane, logic [15:0] act, logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s lane %0d actual %h expected %h", phase, what, lane, act, exp);
        end
    endtask

    // Compare all outputs away from the active edge, once the model is settled.
    always @(negedge clk) begin
        if (m_sem[0] !== 16'hx && !done) begin
            cmp("get R2", 0, dsp_get, m_sem[0]);
            cmp("get R2", 1, host_get, m_sem[1]);
            cmp("mask R9", 0, dsp_mask, m_msk[0]);
            cmp("mask R9", 1, host_mask, m_msk[1]);
            cmp("summary R6", 0, {15'h0, dsp_summary}, {15'h0, sum_of(0)});
            cmp("summary R6", 1, {15'h0, host_summary}, {15'h0, sum_of(1)});
            cmp("irq R7", 0, {15'h0, dsp_irq}, {15'h0, sum_of(0) & ~m_prev[0]});
            cmp("irq R7", 1, {15'h0, host_irq}, {15'h0, sum_of(1) & ~m_prev[1]});
        end
    end

    // Advance one cycle: let the edge take the inputs, then clear all strobes.
    task automatic tick();
        @(posedge clk); #1;
        h_swe = 0; h_awe = 0; h_mwe = 0;
        d_swe = 0; d_awe = 0; d_mwe = 0;
    endtask

    // Targeted compare with a fixed expectation from the requirement text.
    task automatic expect_val(string tag, logic [15:0] act, logic [15:0] exp);
        @(negedge clk);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %h expected %h", tag, act, exp);
        end
        #1;
    endtask

    initial begin
        #2000000;
        errors++;
        $display("FAIL watchdog expired");
        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        phase = "R1";
        repeat (3) tick();
        rst_n = 1'b1;
        tick();
        expect_val("R1 dsp_get after reset", dsp_get, 16'h0);
        expect_val("R1 host_irq after reset", {15'h0, host_irq}, 16'h0);

        phase = "R2";
        h_swe = 1; h_sb = 16'h0005; tick();
        expect_val("R2 set reaches dsp_get", dsp_get, 16'h0005);
        h_swe = 1; h_sb = 16'h0100; tick();
        expect_val("R7 no second irq while summary held", {15'h0, dsp_irq}, 16'h0);

        phase = "R5";
        expect_val("R5 other lane untouched", host_get, 16'h0);
        d_swe = 1; d_sb = 16'h8000; h_mwe = 1; h_mb = 16'h00FF; tick();
        expect_val("R5 dsp set leaves h2d lane", dsp_get, 16'h0105);

        phase = "R3";
        d_awe = 1; d_ab = 16'h0001; tick();
        expect_val("R3 ack clears one bit", dsp_get, 16'h0104);

        phase = "R4";
        h_swe = 1; h_sb = 16'h0002; d_awe = 1; d_ab = 16'h0006; tick();
        expect_val("R4 set wins over ack", dsp_get, 16'h0102);

        phase = "R8";
        d_mwe = 1; d_mb = 16'hFFFF; tick();
        expect_val("R6 summary drops when fully masked", {15'h0, dsp_summary}, 16'h0);
        d_mwe = 1; d_mb = 16'hFEFF; tick();
        expect_val("R8 unmask raises irq", {15'h0, dsp_irq}, 16'h1);
        tick();
        expect_val("R5 mask write leaves value", dsp_get, 16'h0102);
        expect_val("R9 mask readback", dsp_mask, 16'hFEFF);

        phase = "R7";
        for (int i = 0; i < 400; i++) begin
            h_swe = ($urandom % 4) == 0; h_sb = 16'(1 << ($urandom % 16));
            d_swe = ($urandom % 4) == 0; d_sb = 16'(1 << ($urandom % 16));
            h_awe = ($urandom % 3) == 0; h_ab = 16'($urandom);
            d_awe = ($urandom % 3) == 0; d_ab = 16'($urandom);
            h_mwe = ($urandom % 8) == 0; h_mb = 16'($urandom);
            d_mwe = ($urandom % 8) == 0; d_mb = 16'($urandom);
            tick();
        end
        repeat (2) tick();
        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule